// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

The block produces a pulse-width-modulated output from an 8-bit up-counting period timer. A sub-cycle counter runs below the timer. With a 1:1 prescale it steps the timer once every four clocks, and with the 1:4 and 1:16 prescales it steps it proportionally less often. The timer and the two fine bits of the sub-cycle counter together form a 10-bit time base. The output period is 4 × (period + 1) × prescale clocks.

Software programs the period, the duty value and the prescale through a small register port. The duty value is 10 bits wide: a high byte in one register and two low bits in a control register. Duty writes may land at any time. The comparator works against a shadow copy of the duty value, and that copy is reloaded only when a period ends, so a mid-period write never produces a glitch. The output rises at the start of each period and falls when the time base reaches the shadow duty. This gives a high time of duty × prescale clocks.

Top module: `pwm_gen`

## Requirements
- R1: After reset the output is low, the timer, the sub-cycle counter and the shadow duty are zero, and every register address reads 0.
- R2: Register map. Address 0 holds the 8-bit period. Address 1 holds the 8-bit duty high byte. Address 2 holds the two duty low bits in bits [1:0] and the prescale select in bits [3:2]. Each of these reads back what was written. Address 3 reads the shadow duty high byte, and writes to address 3 have no effect.
- R3: While enabled, the sub-cycle counter counts from 0 to 4×P−1, where P is the prescale ratio. The timer increments when the sub-cycle counter wraps, and it returns to 0 on the wrap that follows its being equal to the period, so one period lasts 4×(period+1)×P clocks.
- R4: On the wrap where the timer equals the period, the shadow duty is loaded from the duty registers and the output goes high, unless the loaded value is zero.
- R5: A duty write made inside a period changes neither the shadow duty (read at address 3) nor the output until the next period boundary.
- R6: The output goes low on the clock at which the 10-bit time base {timer, sub-cycle counter divided by P} becomes equal to the shadow duty. Each period is therefore high for duty×P clocks.
- R7: A shadow duty of zero keeps the output low for the whole period.
- R8: A shadow duty not less than 4×(period+1) keeps the output high for the whole period.
- R9: The prescale select encodes 2'b00 as 1:1, 2'b01 as 1:4, and 2'b10 or 2'b11 as 1:16.
- R10: While the enable is low, the timer and the sub-cycle counter hold their values and the output is low from the next clock on. After the enable returns, the output stays low until the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmEn | input | 1 | Run enable for the time base and output |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| pwmOut | output | 1 | PWM output |

## Verification
The assertions assume that the prescale select changes only while the sub-cycle counter is at zero. If it changed elsewhere, the counter could sit above the new terminal count, and the timer-step and period-start properties would no longer describe the waveform. The stimulus therefore writes the prescale only straight after reset, before the enable is raised. The period is also left alone while the timer runs, so the timer never has to pass a lowered period. Duty writes, by contrast, are made deliberately in the middle of a period and at arbitrary phases.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  typedef struct packed {
    logic advance;    // time base may move this clock
    logic subWrap;    // sub-cycle counter wraps to zero
    logic periodHit;  // wrap while timer equals period
    logic dutyMatch;  // next time base equals shadow duty
  } pwmStrobe_t;

  localparam logic [1:0] ADDR_PERIOD  = 2'd0;
  localparam logic [1:0] ADDR_DUTY_HI = 2'd1;
  localparam logic [1:0] ADDR_CTRL    = 2'd2;
  localparam logic [1:0] ADDR_SHADOW  = 2'd3;

endpackage

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_gen_pkg::*;
#(
  parameter int TMR_W     = 8,
  parameter int FINE_W    = 2,
  parameter int SEL_W     = 2,
  parameter int MAX_SHIFT = 4,
  localparam int DUTY_W   = TMR_W + FINE_W,
  localparam int SUB_W    = FINE_W + MAX_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [TMR_W-1:0]  wrData,
  input  logic [1:0]        rdAddr,
  output logic [TMR_W-1:0]  rdData,
  input  pwmStrobe_t        strobe,
  output logic              subAtEnd,
  output logic              tmrAtPeriod,
  output logic              nextEqShadow,
  output logic              pendingNonZero,
  output logic [TMR_W-1:0]  tmrVal,
  output logic [SUB_W-1:0]  subVal,
  output logic [DUTY_W-1:0] shadowVal
);

  logic [TMR_W-1:0]  periodReg;
  logic [TMR_W-1:0]  dutyHi;
  logic [FINE_W-1:0] dutyLo;
  logic [SEL_W-1:0]  preSel;
  logic [TMR_W-1:0]  tmrCnt;
  logic [SUB_W-1:0]  subCnt;
  logic [DUTY_W-1:0] shadowDuty;

  int                shiftAmt;
  logic [SUB_W-1:0]  subLast;
  logic [SUB_W-1:0]  nextSub;
  logic [TMR_W-1:0]  nextTmr;
  logic [FINE_W-1:0] nextFine;

  // prescale select -> right shift of the sub-cycle counter
  always_comb begin
    shiftAmt = 2 * int'(preSel);
    if (shiftAmt > MAX_SHIFT) shiftAmt = MAX_SHIFT;
  end

  assign subLast        = SUB_W'((1 << (FINE_W + shiftAmt)) - 1);
  assign subAtEnd       = (subCnt >= subLast);
  assign tmrAtPeriod    = (tmrCnt == periodReg);
  assign nextSub        = subAtEnd ? '0 : subCnt + 1'b1;
  assign nextTmr        = subAtEnd ? tmrCnt + 1'b1 : tmrCnt;
  assign nextFine       = FINE_W'(nextSub >> shiftAmt);
  assign nextEqShadow   = ({nextTmr, nextFine} == shadowDuty);
  assign pendingNonZero = ({dutyHi, dutyLo} != '0);

  // software registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '0;
      dutyHi    <= '0;
      dutyLo    <= '0;
      preSel    <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_PERIOD:  periodReg <= wrData;
        ADDR_DUTY_HI: dutyHi    <= wrData;
        ADDR_CTRL: begin
          dutyLo <= wrData[FINE_W-1:0];
          preSel <= wrData[FINE_W +: SEL_W];
        end
        default: ;
      endcase
    end
  end

  // time base and shadow duty
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt     <= '0;
      subCnt     <= '0;
      shadowDuty <= '0;
    end else if (strobe.advance) begin
      if (strobe.subWrap) begin
        subCnt <= '0;
        if (strobe.periodHit) begin
          tmrCnt     <= '0;
          shadowDuty <= {dutyHi, dutyLo};
        end else begin
          tmrCnt <= tmrCnt + 1'b1;
        end
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_PERIOD:  rdData = periodReg;
      ADDR_DUTY_HI: rdData = dutyHi;
      ADDR_CTRL:    rdData = TMR_W'({preSel, dutyLo});
      default:      rdData = shadowDuty[DUTY_W-1 -: TMR_W];
    endcase
  end

  assign tmrVal    = tmrCnt;
  assign subVal    = subCnt;
  assign shadowVal = shadowDuty;

endmodule

// File: rtl/pwm_control.sv
module pwm_control
  import pwm_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwmEn,
  input  logic       subAtEnd,
  input  logic       tmrAtPeriod,
  input  logic       nextEqShadow,
  input  logic       pendingNonZero,
  output pwmStrobe_t strobe,
  output logic       pwmOut
);

  always_comb begin
    strobe.advance   = pwmEn;
    strobe.subWrap   = pwmEn & subAtEnd;
    strobe.periodHit = pwmEn & subAtEnd & tmrAtPeriod;
    strobe.dutyMatch = pwmEn & ~strobe.periodHit & nextEqShadow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pwmOut <= 1'b0;
    else if (!pwmEn)           pwmOut <= 1'b0;
    else if (strobe.periodHit) pwmOut <= pendingNonZero;
    else if (strobe.dutyMatch) pwmOut <= 1'b0;
  end

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter int TMR_W     = 8,
  parameter int FINE_W    = 2,
  parameter int SEL_W     = 2,
  parameter int MAX_SHIFT = 4,
  localparam int DUTY_W   = TMR_W + FINE_W,
  localparam int SUB_W    = FINE_W + MAX_SHIFT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwmEn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [TMR_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [TMR_W-1:0] rdData,
  output logic             pwmOut
);

  pwmStrobe_t        strobe;
  logic              subAtEnd, tmrAtPeriod, nextEqShadow, pendingNonZero;
  logic [TMR_W-1:0]  tmrVal;
  logic [SUB_W-1:0]  subVal;
  logic [DUTY_W-1:0] shadowVal;

  pwm_datapath #(
    .TMR_W(TMR_W), .FINE_W(FINE_W), .SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .strobe(strobe),
    .subAtEnd(subAtEnd), .tmrAtPeriod(tmrAtPeriod),
    .nextEqShadow(nextEqShadow), .pendingNonZero(pendingNonZero),
    .tmrVal(tmrVal), .subVal(subVal), .shadowVal(shadowVal)
  );

  pwm_control u_ctl (
    .clk(clk), .rstN(rstN), .pwmEn(pwmEn),
    .subAtEnd(subAtEnd), .tmrAtPeriod(tmrAtPeriod),
    .nextEqShadow(nextEqShadow), .pendingNonZero(pendingNonZero),
    .strobe(strobe), .pwmOut(pwmOut)
  );

endmodule

// File: rtl/pwm_gen_checker.sv
module pwm_gen_checker #(
  parameter int TMR_W  = 8,
  parameter int SUB_W  = 6,
  parameter int DUTY_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              pwmEn,
  input logic              pwmOut,
  input logic [TMR_W-1:0]  tmrVal,
  input logic [SUB_W-1:0]  subVal,
  input logic [DUTY_W-1:0] shadowVal
);

  // R10
  disable_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwmEn |=> !pwmOut);

  // R10
  disable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwmEn |=> ($stable(tmrVal) && $stable(subVal)));

  // R4
  rise_at_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> (tmrVal == '0 && subVal == '0));

  // R5
  shadow_at_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(shadowVal) |-> (tmrVal == '0 && subVal == '0));

  // R3
  timer_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tmrVal) |-> (tmrVal == '0 || tmrVal == $past(tmrVal) + 1'b1));

  // R7
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tmrVal == '0 && subVal == '0 && shadowVal == '0) |-> !pwmOut);

endmodule

bind pwm_gen pwm_gen_checker #(
  .TMR_W(TMR_W), .SUB_W(SUB_W), .DUTY_W(DUTY_W)
) u_chk (
  .clk(clk), .rstN(rstN), .pwmEn(pwmEn), .pwmOut(pwmOut),
  .tmrVal(tmrVal), .subVal(subVal), .shadowVal(shadowVal)
);

// File: tb/sim_pwm_gen.sv
`timescale 1ns/1ps
module sim_pwm_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwmEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       pwmOut;

  int nChecks = 0;
  int nFail = 0;
  string phaseReq = "R1";

  // behavioural reference state
  int        mSub = 0, mTmr = 0, mPer = 0, mPre = 0;
  logic [9:0] mDuty = '0, mShadow = '0;
  logic      mOut = 1'b0;

  always #10 clk = ~clk;

  pwm_gen u0 (
    .clk(clk), .rstN(rstN), .pwmEn(pwmEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .pwmOut(pwmOut)
  );

  function automatic int ratio(int sel);
    if (sel == 0) return 1;
    if (sel == 1) return 4;
    return 16;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSub = 0; mTmr = 0; mPer = 0; mPre = 0;
      mDuty = '0; mShadow = '0; mOut = 1'b0;
    end else begin
      int p;
      bit boundary;
      p = ratio(mPre);
      boundary = 0;
      if (pwmEn) begin
        if (mSub == 4 * p - 1) begin
          mSub = 0;
          if (mTmr == mPer) begin
            mTmr = 0; mShadow = mDuty; boundary = 1; mOut = (mDuty != 0);
          end else mTmr++;
        end else mSub++;
        if (!boundary && (mTmr * 4 + mSub / p) == int'(mShadow)) mOut = 1'b0;
      end else mOut = 1'b0;
      if (wrEn) begin
        case (wrAddr)
          2'd0: mPer = int'(wrData);
          2'd1: mDuty[9:2] = wrData;
          2'd2: begin mDuty[1:0] = wrData[1:0]; mPre = int'(wrData[3:2]); end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, bit ok, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rstN) check(phaseReq, pwmOut == mOut, int'(pwmOut), int'(mOut));
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(string req, logic [1:0] a, int exp);
    rdAddr = a;
    #1;
    check(req, int'(rdData) == exp, int'(rdData), exp);
  endtask

  task automatic highCount(string req, int n, int exp);
    int c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut) c++;
    end
    check(req, c == exp, c, exp);
  endtask

  task automatic doReset();
    pwmEn = 1'b0; rstN = 1'b0;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
  endtask

  initial begin
    #(20 * 100000);
    nFail++; nChecks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    bit prevOut;
    doReset();
    // R1 reset state
    phaseReq = "R1";
    check("R1", pwmOut == 1'b0, int'(pwmOut), 0);
    for (int a = 0; a < 4; a++) rd("R1", 2'(a), 0);

    // R2 register port
    phaseReq = "R2";
    wr(2'd0, 8'd3);
    wr(2'd1, 8'd2);
    wr(2'd2, 8'h01);
    rd("R2", 2'd0, 3);
    rd("R2", 2'd1, 2);
    rd("R2", 2'd2, 1);
    wr(2'd3, 8'hAA);
    rd("R2", 2'd3, 0);

    // R3 R4 R6: duty 9, period span 16 clocks at 1:1
    phaseReq = "R3,R4,R6";
    pwmEn = 1'b1;
    cyc(40);
    rd("R4", 2'd3, 2);
    highCount("R6", 32, 18);

    // R5: mid-period write held off until boundary
    phaseReq = "R5";
    do begin prevOut = pwmOut; @(negedge clk); end while (!(pwmOut && !prevOut));
    wr(2'd1, 8'd1);
    for (int i = 0; i < 10; i++) begin rd("R5", 2'd3, 2); cyc(1); end
    cyc(16);
    rd("R5", 2'd3, 1);
    cyc(16);
    highCount("R5", 32, 10);

    // R7 zero duty
    phaseReq = "R7";
    wr(2'd1, 8'd0);
    wr(2'd2, 8'h00);
    cyc(40);
    highCount("R7", 32, 0);

    // R8 duty equal to span and above span
    phaseReq = "R8";
    wr(2'd1, 8'd4);
    cyc(40);
    highCount("R8", 32, 32);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h03);
    cyc(40);
    highCount("R8", 32, 32);

    // R10 enable low
    phaseReq = "R10";
    pwmEn = 1'b0;
    cyc(1);
    check("R10", pwmOut == 1'b0, int'(pwmOut), 0);
    highCount("R10", 10, 0);
    pwmEn = 1'b1;
    cyc(40);

    // R9 prescale 1:4 -> period 1, duty 5: 32-clock period, 20 high
    doReset();
    phaseReq = "R9";
    wr(2'd2, 8'h05);
    wr(2'd0, 8'd1);
    wr(2'd1, 8'd1);
    rd("R9", 2'd2, 5);
    pwmEn = 1'b1;
    cyc(70);
    highCount("R9", 64, 40);

    // R9 prescale code 2'b10 -> 1:16, period 0, duty 2: 64-clock period, 32 high
    doReset();
    wr(2'd2, 8'h0A);
    wr(2'd1, 8'd0);
    pwmEn = 1'b1;
    cyc(140);
    highCount("R9", 128, 64);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule